// File: doc/BRIEF.md
# Byte Programming Sequencer with Readback Polling

This block holds a small byte-wide nonvolatile array together with the state machine that times its writes and its whole-array erase. A raw command port accepts one byte write or one erase at a time. Each write runs for a fixed number of clock cycles, and that number depends on which region the address falls in. An erase runs for its own fixed duration and leaves every byte at all ones. While a write is running, a read of the byte being written returns all ones. While an erase is running, every read returns zero.

A second port, the host poller, takes one byte at a time and finishes it without help. For any value other than all ones, it launches the write and compares the readback of that address every cycle until the new value appears. A value of all ones can never be confirmed this way. For that value the poller waits a fixed, region-specific time instead. If the target byte has not been written since the last erase, it skips the write altogether.

Each byte carries an erased-since-write flag that drives the skip rule. The flag is set when an erase finishes and cleared when a write to that byte finishes.

Top module: `nvm_byte_prog`

## Requirements
- R1: After reset the array is idle (`busy` low), every byte reads 8'h00, `cmd_err` and `pw_done` are low, and `pw_ready` is high.
- R2: A raw write accepted while idle keeps `busy` high for FL_WR_CYC cycles when the address is below EE_BASE, and for EE_WR_CYC cycles otherwise. After that the byte holds the written data.
- R3: While a write is running, `rd_data` is 8'hFF for the address under write. Every other address returns its stored byte.
- R4: An accepted erase keeps `busy` high for ERASE_CYC cycles, during which `rd_data` is 8'h00 for every address. Afterwards every byte reads 8'hFF.
- R5: A raw write or erase presented while `busy` is high changes nothing, and `cmd_err` goes high for the one cycle after that request.
- R6: When `wr_req` and `er_req` arrive together while idle, the erase is taken and the write is dropped with a `cmd_err` pulse.
- R7: When the poller launches its write in the same cycle as a raw request, the poller wins and the raw request is dropped with a `cmd_err` pulse.
- R8: For data other than 8'hFF, the poller launches the write as soon as the array is idle and pulses `pw_done` for one cycle, one cycle after the readback first equals the data.
- R9: For data 8'hFF to a byte written since the last erase, the poller launches the write and pulses `pw_done` FL_WAIT cycles (below EE_BASE) or EE_WAIT cycles (otherwise) after launch.
- R10: For data 8'hFF to a byte not written since the last erase, no write is launched (`busy` stays low) and `pw_done` pulses on the cycle after the request is taken.
- R11: A finished write to a byte clears its erased-since-write flag, so a later 8'hFF to that byte follows R9 and not R10.
- R12: `pw_req` is taken only while `pw_ready` is high. A request made while it is low has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Raw byte write request |
| wr_addr | input | ADDR_W | Raw write address |
| wr_data | input | DATA_W | Raw write data |
| er_req | input | 1 | Whole-array erase request |
| cmd_err | output | 1 | One-cycle pulse for a dropped raw request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| busy | output | 1 | A write or erase cycle is running |
| pw_req | input | 1 | Poller byte request |
| pw_addr | input | ADDR_W | Poller target address |
| pw_data | input | DATA_W | Poller data |
| pw_ready | output | 1 | Poller idle, may take a request |
| pw_done | output | 1 | One-cycle pulse when the poller byte is finished |

## Verification
Two functions can land in the same cycle. The first is the poller's launch against a raw write request. The bench provokes it by raising `wr_req` on exactly the cycle the poller leaves its issue state, then expects the raw request to be dropped with `cmd_err` and the poller's byte to land. The second is a raw write against a raw erase on an idle array. The bench expects the erase duration, zero reads during the erase, and all-ones afterwards, which proves the write had no effect. A behavioural model inside the bench predicts `busy`, `rd_data`, `cmd_err`, `pw_ready` and `pw_done` on every cycle. Spot checks also measure launch-to-done latency for the poll, fixed-wait and skip paths in both regions.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

   typedef enum logic [1:0] {
      ARR_IDLE  = 2'd0,
      ARR_WRITE = 2'd1,
      ARR_ERASE = 2'd2
   } arr_state_e;

   typedef enum logic [1:0] {
      PL_IDLE  = 2'd0,
      PL_ISSUE = 2'd1,
      PL_POLL  = 2'd2,
      PL_HOLD  = 2'd3
   } poll_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      return max2(max2(a, b), c);
   endfunction

endpackage

// File: rtl/nvm_region_map.sv
module nvm_region_map #(
   parameter int ADDR_W  = 4,
   parameter int EE_BASE = 8,
   parameter bit HAS_EE  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_ee
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(EE_BASE);

   generate
      if (HAS_EE) begin : g_split
         assign is_ee = (addr >= BASE_A);
      end else begin : g_flat
         logic unused_addr;
         assign unused_addr = ^addr;
         assign is_ee = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/nvm_cell_store.sv
module nvm_cell_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              commit_wr,
   input  logic [ADDR_W-1:0]                 commit_addr,
   input  logic [DATA_W-1:0]                 commit_data,
   input  logic                              commit_erase,
   output wire  [(1<<ADDR_W)-1:0][DATA_W-1:0] cells_o,
   output wire  [(1<<ADDR_W)-1:0]            erased_o
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         logic [DATA_W-1:0] q;
         logic              e;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
               e <= 1'b0;
            end else if (commit_erase) begin
               q <= '1;
               e <= 1'b1;
            end else if (commit_wr && (commit_addr == ADDR_W'(g))) begin
               q <= commit_data;
               e <= 1'b0;
            end
         end
         assign cells_o[g]  = q;
         assign erased_o[g] = e;
      end
   endgenerate

endmodule

// File: rtl/nvm_cycle_seq.sv
module nvm_cycle_seq
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int EE_BASE   = 8,
   parameter bit HAS_EE    = 1'b1,
   parameter int FL_WR_CYC = 5,
   parameter int EE_WR_CYC = 9,
   parameter int ERASE_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              start_er,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   output arr_state_e        st,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_data,
   output logic              commit_wr,
   output logic              commit_erase
);

   localparam int MAXC = max3(FL_WR_CYC, EE_WR_CYC, ERASE_CYC);
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] FL_LD = CNT_W'(FL_WR_CYC - 1);
   localparam logic [CNT_W-1:0] EE_LD = CNT_W'(EE_WR_CYC - 1);
   localparam logic [CNT_W-1:0] ER_LD = CNT_W'(ERASE_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             s_is_ee;
   logic [CNT_W-1:0] wr_ld;

   nvm_region_map #(
      .ADDR_W (ADDR_W),
      .EE_BASE(EE_BASE),
      .HAS_EE (HAS_EE)
   ) u_map (
      .addr (s_addr),
      .is_ee(s_is_ee)
   );

   assign wr_ld        = s_is_ee ? EE_LD : FL_LD;
   assign busy         = (st != ARR_IDLE);
   assign commit_wr    = (st == ARR_WRITE) && (cnt == '0);
   assign commit_erase = (st == ARR_ERASE) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ARR_IDLE;
         cnt      <= '0;
         cur_addr <= '0;
         cur_data <= '0;
      end else begin
         case (st)
            ARR_IDLE: begin
               if (start_wr) begin
                  st       <= ARR_WRITE;
                  cnt      <= wr_ld;
                  cur_addr <= s_addr;
                  cur_data <= s_data;
               end else if (start_er) begin
                  st  <= ARR_ERASE;
                  cnt <= ER_LD;
               end
            end
            ARR_WRITE, ARR_ERASE: begin
               if (cnt == '0) begin
                  st <= ARR_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= ARR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvm_read_mux.sv
module nvm_read_mux
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  arr_state_e                        st,
   input  logic [ADDR_W-1:0]                 cur_addr,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] cells,
   output logic [DATA_W-1:0]                 q
);

   always_comb begin
      if (st == ARR_ERASE) begin
         q = '0;
      end else if ((st == ARR_WRITE) && (addr == cur_addr)) begin
         q = '1;
      end else begin
         q = cells[addr];
      end
   end

endmodule

// File: rtl/nvm_host_poller.sv
module nvm_host_poller
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int EE_BASE = 8,
   parameter bit HAS_EE  = 1'b1,
   parameter int FL_WAIT = 7,
   parameter int EE_WAIT = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pw_req,
   input  logic [ADDR_W-1:0]      pw_addr,
   input  logic [DATA_W-1:0]      pw_data,
   input  logic                   arr_busy,
   input  logic [(1<<ADDR_W)-1:0] erased,
   input  logic [DATA_W-1:0]      poll_q,
   output logic [ADDR_W-1:0]      p_addr,
   output logic [DATA_W-1:0]      p_data,
   output logic                   issue,
   output logic                   ready,
   output logic                   done
);

   localparam int CNT_W = $clog2(max2(FL_WAIT, EE_WAIT) + 1);
   localparam logic [CNT_W-1:0] FL_LD = CNT_W'(FL_WAIT - 1);
   localparam logic [CNT_W-1:0] EE_LD = CNT_W'(EE_WAIT - 1);

   poll_state_e      st;
   logic [CNT_W-1:0] cnt;
   logic             p_is_ee;
   logic             all_ones;
   logic             skip;

   nvm_region_map #(
      .ADDR_W (ADDR_W),
      .EE_BASE(EE_BASE),
      .HAS_EE (HAS_EE)
   ) u_map (
      .addr (p_addr),
      .is_ee(p_is_ee)
   );

   assign all_ones = (p_data == '1);
   assign skip     = all_ones && erased[p_addr];
   assign issue    = (st == PL_ISSUE) && !arr_busy && !skip;
   assign ready    = (st == PL_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PL_IDLE;
         cnt    <= '0;
         p_addr <= '0;
         p_data <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            PL_IDLE: begin
               if (pw_req) begin
                  p_addr <= pw_addr;
                  p_data <= pw_data;
                  st     <= PL_ISSUE;
               end
            end
            PL_ISSUE: begin
               if (!arr_busy) begin
                  if (skip) begin
                     done <= 1'b1;
                     st   <= PL_IDLE;
                  end else if (all_ones) begin
                     cnt <= p_is_ee ? EE_LD : FL_LD;
                     st  <= PL_HOLD;
                  end else begin
                     st <= PL_POLL;
                  end
               end
            end
            PL_POLL: begin
               if (poll_q == p_data) begin
                  done <= 1'b1;
                  st   <= PL_IDLE;
               end
            end
            PL_HOLD: begin
               if (cnt == '0) begin
                  done <= 1'b1;
                  st   <= PL_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= PL_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvm_byte_prog.sv
module nvm_byte_prog
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int EE_BASE   = 8,
   parameter bit HAS_EE    = 1'b1,
   parameter int FL_WR_CYC = 5,
   parameter int EE_WR_CYC = 9,
   parameter int ERASE_CYC = 16,
   parameter int FL_WAIT   = 7,
   parameter int EE_WAIT   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              er_req,
   output logic              cmd_err,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   input  logic              pw_req,
   input  logic [ADDR_W-1:0] pw_addr,
   input  logic [DATA_W-1:0] pw_data,
   output logic              pw_ready,
   output logic              pw_done
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NRPORT = 2;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_chk_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("DATA_W must be positive");
   end
   if (HAS_EE && (EE_BASE < 1 || EE_BASE >= DEPTH)) begin : g_chk_base
      $error("EE_BASE must split the array");
   end
   if (FL_WR_CYC < 1 || EE_WR_CYC < 1 || ERASE_CYC < 1) begin : g_chk_cyc
      $error("cycle counts must be at least one");
   end
   if (FL_WAIT < FL_WR_CYC || EE_WAIT < EE_WR_CYC) begin : g_chk_wait
      $error("fixed wait shorter than write time");
   end

   arr_state_e                  seq_st;
   logic [ADDR_W-1:0]           cur_addr;
   logic [DATA_W-1:0]           cur_data;
   logic                        commit_wr;
   logic                        commit_er;
   wire  [DEPTH-1:0][DATA_W-1:0] cells;
   wire  [DEPTH-1:0]            erased;
   logic                        issue;
   logic [ADDR_W-1:0]           pol_addr;
   logic [DATA_W-1:0]           pol_data;
   logic [DATA_W-1:0]           poll_q;
   logic                        acc_wr;
   logic                        acc_er;
   logic                        start_wr;
   logic [ADDR_W-1:0]           s_addr;
   logic [DATA_W-1:0]           s_data;
   logic                        err_q;
   wire  [NRPORT-1:0][ADDR_W-1:0] mx_addr;
   wire  [NRPORT-1:0][DATA_W-1:0] mx_q;

   // raw commands only land on an idle array and never against a poller launch
   assign acc_er   = er_req && !busy && !issue;
   assign acc_wr   = wr_req && !busy && !issue && !er_req;
   assign start_wr = issue || acc_wr;
   assign s_addr   = issue ? pol_addr : wr_addr;
   assign s_data   = issue ? pol_data : wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= (er_req && !acc_er) || (wr_req && !acc_wr);
      end
   end
   assign cmd_err = err_q;

   nvm_cycle_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EE_BASE  (EE_BASE),
      .HAS_EE   (HAS_EE),
      .FL_WR_CYC(FL_WR_CYC),
      .EE_WR_CYC(EE_WR_CYC),
      .ERASE_CYC(ERASE_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_wr    (start_wr),
      .start_er    (acc_er),
      .s_addr      (s_addr),
      .s_data      (s_data),
      .st          (seq_st),
      .busy        (busy),
      .cur_addr    (cur_addr),
      .cur_data    (cur_data),
      .commit_wr   (commit_wr),
      .commit_erase(commit_er)
   );

   nvm_cell_store #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_wr   (commit_wr),
      .commit_addr (cur_addr),
      .commit_data (cur_data),
      .commit_erase(commit_er),
      .cells_o     (cells),
      .erased_o    (erased)
   );

   assign mx_addr[0] = rd_addr;
   assign mx_addr[1] = pol_addr;
   assign rd_data    = mx_q[0];
   assign poll_q     = mx_q[1];

   generate
      for (genvar p = 0; p < NRPORT; p++) begin : g_rd
         nvm_read_mux #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
         ) u_mux (
            .st      (seq_st),
            .cur_addr(cur_addr),
            .addr    (mx_addr[p]),
            .cells   (cells),
            .q       (mx_q[p])
         );
      end
   endgenerate

   nvm_host_poller #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .EE_BASE(EE_BASE),
      .HAS_EE (HAS_EE),
      .FL_WAIT(FL_WAIT),
      .EE_WAIT(EE_WAIT)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .pw_req  (pw_req),
      .pw_addr (pw_addr),
      .pw_data (pw_data),
      .arr_busy(busy),
      .erased  (erased),
      .poll_q  (poll_q),
      .p_addr  (pol_addr),
      .p_data  (pol_data),
      .issue   (issue),
      .ready   (pw_ready),
      .done    (pw_done)
   );

endmodule

// File: rtl/nvm_byte_prog_chk.sv
module nvm_byte_prog_chk
   import nvm_prog_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              er_req,
   input logic              cmd_err,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              pw_req,
   input logic              pw_ready,
   input logic              pw_done,
   input arr_state_e        st,
   input logic              issue,
   input logic [ADDR_W-1:0] pol_addr
);

   // R5: an error pulse always follows a raw request
   a_r5_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(wr_req || er_req));

   // R2: the array only becomes busy because something started it
   a_r2_busy_started: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_req || er_req || issue));

   // R4: every read is zero while erasing
   a_r4_erase_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ARR_ERASE) |-> (rd_data == '0));

   // R6: simultaneous raw write and erase on an idle array
   a_r6_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && er_req && !busy && !issue) |=> (st == ARR_ERASE && cmd_err));

   // R7: a poller launch drops a coincident raw request
   a_r7_poller_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (wr_req || er_req)) |=> (cmd_err && st == ARR_WRITE));

   // R8: completion returns the poller to idle
   a_r8_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
      pw_done |-> pw_ready);

   // R12: a request while not ready leaves the latched target alone
   a_r12_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_req && !pw_ready) |=> $stable(pol_addr));

endmodule

bind nvm_byte_prog nvm_byte_prog_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_req  (wr_req),
   .er_req  (er_req),
   .cmd_err (cmd_err),
   .rd_data (rd_data),
   .busy    (busy),
   .pw_req  (pw_req),
   .pw_ready(pw_ready),
   .pw_done (pw_done),
   .st      (seq_st),
   .issue   (issue),
   .pol_addr(pol_addr)
);

// File: tb/sim_nvm_byte_prog.sv
module sim_nvm_byte_prog;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int EB = 8;
   localparam int FLW = 5;
   localparam int EEW = 9;
   localparam int ERC = 16;
   localparam int FLT = 7;
   localparam int EET = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic er_req = 1'b0;
   logic cmd_err;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic busy;
   logic pw_req = 1'b0;
   logic [AW-1:0] pw_addr = '0;
   logic [DW-1:0] pw_data = '0;
   logic pw_ready;
   logic pw_done;

   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;

   always #4 clk = ~clk;

   nvm_byte_prog #(
      .ADDR_W(AW), .DATA_W(DW), .EE_BASE(EB), .HAS_EE(1'b1),
      .FL_WR_CYC(FLW), .EE_WR_CYC(EEW), .ERASE_CYC(ERC),
      .FL_WAIT(FLT), .EE_WAIT(EET)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .er_req(er_req), .cmd_err(cmd_err),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
      .pw_req(pw_req), .pw_addr(pw_addr), .pw_data(pw_data),
      .pw_ready(pw_ready), .pw_done(pw_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_mem[16];
   bit m_er[16];
   int m_st = 0;    // 0 idle, 1 write, 2 erase
   int m_cnt = 0;
   int m_wa = 0;
   int m_wd = 0;
   bit m_err = 0;
   int p_st = 0;    // 0 idle, 1 issue, 2 poll, 3 hold
   int p_addr = 0;
   int p_data = 0;
   int p_cnt = 0;
   bit m_done = 0;

   function automatic int rdv(input int a);
      if (m_st == 2) return 0;
      if (m_st == 1 && a == m_wa) return 255;
      return m_mem[a];
   endfunction

   function automatic int wdur(input int a);
      return (a >= EB) ? EEW : FLW;
   endfunction

   function automatic int wwait(input int a);
      return (a >= EB) ? EET : FLT;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            m_mem[i] = 0;
            m_er[i] = 0;
         end
         m_st = 0; m_cnt = 0; m_err = 0;
         p_st = 0; p_cnt = 0; p_addr = 0; p_data = 0; m_done = 0;
      end else begin
         automatic int rpoll = rdv(p_addr);
         automatic bit idle = (m_st == 0);
         automatic bit skp = (p_data == 255) && m_er[p_addr];
         automatic bit iss = (p_st == 1) && idle && !skp;
         automatic bit aer = er_req && idle && !iss;
         automatic bit awr = wr_req && idle && !iss && !er_req;
         m_err = (er_req && !aer) || (wr_req && !awr);
         case (m_st)
            1: if (m_cnt == 0) begin
                  m_mem[m_wa] = m_wd; m_er[m_wa] = 0; m_st = 0;
               end else m_cnt--;
            2: if (m_cnt == 0) begin
                  for (int i = 0; i < 16; i++) begin
                     m_mem[i] = 255; m_er[i] = 1;
                  end
                  m_st = 0;
               end else m_cnt--;
            default: begin
               if (iss) begin
                  m_st = 1; m_wa = p_addr; m_wd = p_data; m_cnt = wdur(p_addr) - 1;
               end else if (aer) begin
                  m_st = 2; m_cnt = ERC - 1;
               end else if (awr) begin
                  m_st = 1; m_wa = int'(wr_addr); m_wd = int'(wr_data);
                  m_cnt = wdur(int'(wr_addr)) - 1;
               end
            end
         endcase
         m_done = 0;
         case (p_st)
            0: if (pw_req) begin
                  p_addr = int'(pw_addr); p_data = int'(pw_data); p_st = 1;
               end
            1: if (idle) begin
                  if (skp) begin m_done = 1; p_st = 0; end
                  else if (p_data == 255) begin p_cnt = wwait(p_addr) - 1; p_st = 3; end
                  else p_st = 2;
               end
            2: if (rpoll == p_data) begin m_done = 1; p_st = 0; end
            default: if (p_cnt == 0) begin m_done = 1; p_st = 0; end
                     else p_cnt--;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         chk("R2 busy vs model", int'(busy), int'(m_st != 0));
         chk("R3 rd_data vs model", int'(rd_data), rdv(int'(rd_addr)));
         chk("R5 cmd_err vs model", int'(cmd_err), int'(m_err));
         chk("R8 pw_done vs model", int'(pw_done), int'(m_done));
         chk("R12 pw_ready vs model", int'(pw_ready), int'(p_st == 0));
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      rd_addr = AW'(a);
      #1;
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic raw_wr(input int a, input int d);
      wr_req = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      step();
      wr_req = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 1;
      step();
      while (busy) begin
         n++;
         step();
      end
      n--;
   endtask

   task automatic run_pw(input int a, input int d, output int n, output int busy_seen);
      pw_req = 1'b1; pw_addr = AW'(a); pw_data = DW'(d);
      busy_seen = 0;
      step();
      pw_req = 1'b0;
      n = 1;
      while (!pw_done) begin
         if (busy) busy_seen = 1;
         step();
         n++;
      end
      step();
   endtask

   initial begin
      int n;
      int bs;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 pw_ready after reset", int'(pw_ready), 1);
      chk("R1 cmd_err after reset", int'(cmd_err), 0);
      rd_chk(5, 0, "R1 read after reset");

      // R2 / R3 flash write
      rd_addr = AW'(2);
      raw_wr(2, 8'h5A);
      chk("R3 byte under write reads ones", int'(rd_data), 8'hFF);
      rd_chk(3, 0, "R3 other byte during write");
      busy_len(n);
      chk("R2 flash write duration", n + 1, FLW);
      rd_chk(2, 8'h5A, "R2 flash byte landed");

      // R2 eeprom write, R5 request while busy
      raw_wr(9, 8'h3C);
      wr_req = 1'b1; wr_addr = AW'(1); wr_data = 8'h77;
      step();
      wr_req = 1'b0;
      chk("R5 err pulse on busy write", int'(cmd_err), 1);
      step();
      chk("R5 err pulse is single", int'(cmd_err), 0);
      busy_len(n);
      rd_chk(9, 8'h3C, "R2 eeprom byte landed");
      rd_chk(1, 0, "R5 busy write dropped");
      raw_wr(10, 8'h01);
      busy_len(n);
      chk("R2 eeprom write duration", n + 1, EEW);

      // R6 + R4 write and erase together
      wr_req = 1'b1; er_req = 1'b1; wr_addr = AW'(5); wr_data = 8'h11;
      step();
      wr_req = 1'b0; er_req = 1'b0;
      chk("R6 write dropped err", int'(cmd_err), 1);
      rd_chk(2, 0, "R4 zero during erase");
      rd_chk(11, 0, "R4 zero during erase hi");
      busy_len(n);
      chk("R4 erase duration", n + 1, ERC);
      for (int i = 0; i < 16; i++) rd_chk(i, 8'hFF, "R4 ones after erase");

      // R10 skip on erased byte
      run_pw(4, 8'hFF, n, bs);
      chk("R10 skip latency", n, 2);
      chk("R10 no write launched", bs, 0);
      // R8 poll path flash
      run_pw(4, 8'hA5, n, bs);
      chk("R8 poll latency flash", n, FLW + 3);
      rd_chk(4, 8'hA5, "R8 polled byte landed");
      // R11 / R9 fixed wait after rewrite
      run_pw(4, 8'hFF, n, bs);
      chk("R11 rewritten ones not skipped", bs, 1);
      chk("R9 fixed wait flash", n, FLT + 2);
      rd_chk(4, 8'hFF, "R9 ones landed");
      run_pw(12, 8'h77, n, bs);
      chk("R8 poll latency eeprom", n, EEW + 3);
      run_pw(12, 8'hFF, n, bs);
      chk("R9 fixed wait eeprom", n, EET + 2);

      // R7 poller launch against raw write
      pw_req = 1'b1; pw_addr = AW'(6); pw_data = 8'h42;
      step();
      pw_req = 1'b0;
      wr_req = 1'b1; wr_addr = AW'(3); wr_data = 8'h11;
      step();
      wr_req = 1'b0;
      chk("R7 raw dropped on launch", int'(cmd_err), 1);
      while (!pw_done) step();
      step();
      rd_chk(6, 8'h42, "R7 poller byte landed");
      rd_chk(3, 8'hFF, "R7 raw byte untouched");

      // R12 request while not ready
      pw_req = 1'b1; pw_addr = AW'(7); pw_data = 8'h33;
      step();
      pw_addr = AW'(8); pw_data = 8'h99;
      chk("R12 not ready while working", int'(pw_ready), 0);
      step();
      pw_req = 1'b0;
      repeat (30) step();
      rd_chk(7, 8'h33, "R12 first request done");
      rd_chk(8, 8'hFF, "R12 second request ignored");
      chk("R12 array idle afterwards", int'(busy), 0);

      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule